// File: doc/BRIEF.md
# Pipelined Burst Memory Front End

This block puts a synchronous burst interface in front of a small on-chip word memory. Every control input is sampled on the rising clock edge. A cycle with the address strobe low loads a new external address and samples the three chip enables, which decide whether the block takes part in the burst that follows. The cycles after that are continuation beats. On each beat an advance input either steps a 2-bit burst counter or holds the current address as a wait state. The beat writes the word, writes selected lanes of it, or reads it.

The data word is split into lanes of nine bits: eight data bits and one parity bit. A global write strobe writes every lane. Otherwise a byte-write strobe together with per-lane enables picks the lanes to write. Read data passes through two register stages. It is driven only while an asynchronous output enable is low. An asynchronous snooze input freezes the whole block and keeps the memory contents.

Top module: `bsram_front`

## Requirements
- R1: While reset is asserted, and after it is released until the first read completes, `rd_drive` is 0 and `rd_data` is all zeros.
- R2: A load cycle (`ld_n`=0 with `en_a_n`=0) selects the block only if `en_b_n`=0 and `en_c`=1. The selection lasts until the next load cycle. The enables are ignored on every other cycle.
- R3: When `en_a_n`=1, a low `ld_n` is ignored: the burst in progress continues, and a deselected block stays deselected.
- R4: On a selected continuation beat, `adv_n`=0 increments the 2-bit counter that forms address bits [1:0]. The counter wraps from 3 to 0, and bits above bit 1 keep their loaded value. `adv_n`=1 leaves the address unchanged, which is a wait state.
- R5: A selected load cycle is a read of the loaded address, and its write strobes are ignored. A write beat right after the load with `adv_n`=1 writes the loaded address.
- R6: `wr_all_n`=0 on a selected continuation beat writes all lanes, whatever `wr_byte_n` and `lane_n` are.
- R7: With `wr_all_n`=1 and `wr_byte_n`=0, lane i (bits 9i+7..9i, with parity bit 9i+8) is written only if `lane_n[i]`=0. If no lane enable is low, nothing is written and nothing is read.
- R8: A selected beat with both write strobes high reads its address. The word appears on `rd_data` with `rd_drive`=1 after the second rising edge following the capture edge, and for one cycle only.
- R9: A deselected block performs no write and no read.
- R10: `oe_n`=1 forces `rd_drive` to 0 and `rd_data` to zero without waiting for a clock edge. It does not disturb the read pipeline.
- R11: While `snooze`=1, every register and the memory hold their state and all other inputs are ignored. `rd_drive` is forced to 0 at once. After release, operation resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| snooze | input | 1 | Asynchronous freeze, active high |
| addr | input | ADDR_W | Word address, sampled on load cycles |
| ld_n | input | 1 | Address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_a_n | input | 1 | Chip enable, active low; also qualifies the address strobe |
| en_b_n | input | 1 | Second chip enable, active low |
| en_c | input | 1 | Third chip enable, active high |
| wr_all_n | input | 1 | Global write strobe, active low |
| wr_byte_n | input | 1 | Byte-write strobe, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| wr_data | input | 9*LANES | Write data, parity bit at the top of each lane |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rd_drive | output | 1 | Read data is being driven |
| rd_data | output | 9*LANES | Read data, zero when not driven |

## Verification
The bench builds the block with four lanes and a five-bit address. A 32-word memory lets every word be written during the fill. Bursts then reach every aligned four-word group, including the wrap from 3 back to 0 at several base addresses. Four lanes allow mixed lane masks, a mask with no lane enabled, and a global write that overrides a partial mask. Snooze and output-enable changes are placed while reads are in flight in the two-stage pipeline.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int unsigned LANE_W  = 9;
  localparam int unsigned BURST_W = 2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bsram_burst_ctl.sv
// Load capture, chip-select gating and 2-bit linear burst counter.
module bsram_burst_ctl
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               ld_n,
  input  logic               adv_n,
  input  logic               en_a_n,
  input  logic               en_b_n,
  input  logic               en_c,
  output logic               acc_go,
  output logic               acc_load,
  output logic [ADDR_W-1:0]  acc_addr,
  output logic               sel_q,
  output logic [BURST_W-1:0] cnt_q
);
  localparam int unsigned HI_W = ADDR_W - BURST_W;

  logic               load;
  logic               sel_d;
  logic [HI_W-1:0]    hi_q;
  logic [HI_W-1:0]    hi_d;
  logic [BURST_W-1:0] cnt_d;

  // Next state: enables matter only when a new address is taken.
  always_comb begin
    load  = ~ld_n & ~en_a_n;
    sel_d = sel_q;
    hi_d  = hi_q;
    cnt_d = cnt_q;
    if (load) begin
      sel_d = ~en_b_n & en_c;
      hi_d  = addr[ADDR_W-1:BURST_W];
      cnt_d = addr[BURST_W-1:0];
    end else if (sel_q && !adv_n) begin
      cnt_d = cnt_q + 1'b1;
    end
    acc_go   = sel_d;
    acc_load = load;
    acc_addr = {hi_d, cnt_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      hi_q  <= '0;
      cnt_q <= '0;
    end else if (step_en) begin
      sel_q <= sel_d;
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bsram_lane_dec.sv
// Lane write decode: the global strobe has priority over the byte strobe.
module bsram_lane_dec #(
  parameter int unsigned LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  output logic             wr_any,
  output logic [LANES-1:0] lane_we
);
  assign wr_any = ~wr_all_n | ~wr_byte_n;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = ~wr_all_n | (~wr_byte_n & ~lane_n[i]);
  end
endmodule

// File: rtl/bsram_array.sv
// Access register, per-lane storage and two-stage read pipeline.
module bsram_array
  import bsram_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step_en,
  input  op_e                       req_op,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [LANES-1:0]          req_we,
  input  logic [LANES*LANE_W-1:0]   req_data,
  output logic                      out_vld,
  output logic [LANES*LANE_W-1:0]   out_data
);
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  op_e                a_op;
  logic [ADDR_W-1:0]  a_addr;
  logic [LANES-1:0]   a_we;
  logic [DATA_W-1:0]  a_data;
  logic [DATA_W-1:0]  rd_word;
  logic               r_vld;
  logic               r_vld_d;
  logic [DATA_W-1:0]  r_data;
  logic               a_is_wr;

  assign a_is_wr = (a_op == OP_WRITE);
  assign r_vld_d = (a_op == OP_READ);

  // Control registers carry reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_op    <= OP_NONE;
      r_vld   <= 1'b0;
      out_vld <= 1'b0;
    end else if (step_en) begin
      a_op    <= req_op;
      r_vld   <= r_vld_d;
      out_vld <= r_vld;
    end
  end

  // Datapath registers carry no reset.
  always_ff @(posedge clk) begin
    if (step_en) begin
      a_addr <= req_addr;
      a_we   <= req_we;
      a_data <= req_data;
      if (r_vld_d) r_data   <= rd_word;
      if (r_vld)   out_data <= r_data;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_mem
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (step_en && a_is_wr && a_we[g]) begin
        mem[a_addr] <= a_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_word[g*LANE_W +: LANE_W] = mem[a_addr];
  end
endmodule

// File: rtl/bsram_front.sv
module bsram_front
  import bsram_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     snooze,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     ld_n,
  input  logic                     adv_n,
  input  logic                     en_a_n,
  input  logic                     en_b_n,
  input  logic                     en_c,
  input  logic                     wr_all_n,
  input  logic                     wr_byte_n,
  input  logic [LANES-1:0]         lane_n,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  input  logic                     oe_n,
  output logic                     rd_drive,
  output logic [LANES*LANE_W-1:0]  rd_data
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [1:0]         rst_pipe;
  logic               rst_q_n;
  logic               step_en;
  logic               acc_go;
  logic               acc_load;
  logic [ADDR_W-1:0]  acc_addr;
  logic               sel_q;
  logic [BURST_W-1:0] cnt_q;
  logic               wr_any;
  logic [LANES-1:0]   lane_we;
  op_e                op;
  logic               out_vld;
  logic [DATA_W-1:0]  out_data;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // Snooze acts as a clock enable on every register.
  assign step_en = ~snooze;

  bsram_burst_ctl #(.ADDR_W(ADDR_W)) burst_i (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .step_en  (step_en),
    .addr     (addr),
    .ld_n     (ld_n),
    .adv_n    (adv_n),
    .en_a_n   (en_a_n),
    .en_b_n   (en_b_n),
    .en_c     (en_c),
    .acc_go   (acc_go),
    .acc_load (acc_load),
    .acc_addr (acc_addr),
    .sel_q    (sel_q),
    .cnt_q    (cnt_q)
  );

  bsram_lane_dec #(.LANES(LANES)) dec_i (
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_n    (lane_n),
    .wr_any    (wr_any),
    .lane_we   (lane_we)
  );

  // A load cycle is always a read; write strobes count from the next beat.
  always_comb begin
    if (!acc_go)                op = OP_NONE;
    else if (acc_load || !wr_any) op = OP_READ;
    else                        op = OP_WRITE;
  end

  bsram_array #(.LANES(LANES), .ADDR_W(ADDR_W)) array_i (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .step_en  (step_en),
    .req_op   (op),
    .req_addr (acc_addr),
    .req_we   (lane_we),
    .req_data (wr_data),
    .out_vld  (out_vld),
    .out_data (out_data)
  );

  assign rd_drive = out_vld & ~oe_n & ~snooze;
  assign rd_data  = rd_drive ? out_data : '0;
endmodule

// File: rtl/bsram_front_chk.sv
module bsram_front_chk
  import bsram_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 6
) (
  input logic                     clk,
  input logic                     rst_q_n,
  input logic                     snooze,
  input logic                     ld_n,
  input logic                     adv_n,
  input logic                     en_a_n,
  input logic                     en_b_n,
  input logic                     en_c,
  input logic                     wr_all_n,
  input logic                     oe_n,
  input logic                     rd_drive,
  input logic [LANES*LANE_W-1:0]  rd_data,
  input logic                     sel_q,
  input logic [BURST_W-1:0]       cnt_q,
  input logic [LANES-1:0]         lane_we,
  input op_e                      op
);
  // R1
  always_comb begin
    if (rst_q_n == 1'b0) begin
      p_reset_quiet_r1: assert (!rd_drive && rd_data == '0);
    end
  end

  p_load_sel_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!snooze && !ld_n && !en_a_n && !en_b_n && en_c) |=> sel_q);

  p_load_desel_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!snooze && !ld_n && !en_a_n && (en_b_n || !en_c)) |=> !sel_q);

  p_strobe_ignored_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!snooze && !ld_n && en_a_n) |=> (sel_q == $past(sel_q)));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!snooze && sel_q && (ld_n || en_a_n) && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1));

  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!snooze && sel_q && (ld_n || en_a_n) && adv_n) |=> $stable(cnt_q));

  p_load_is_read_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!snooze && !ld_n && !en_a_n && !en_b_n && en_c) |-> (op == OP_READ));

  p_global_all_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!snooze && sel_q && (ld_n || en_a_n) && !wr_all_n) |-> (op == OP_WRITE && &lane_we));

  p_desel_idle_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!sel_q && (ld_n || en_a_n)) |-> (op == OP_NONE));

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    oe_n |-> (!rd_drive && rd_data == '0));

  p_snooze_freeze_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    snooze |=> ($stable(sel_q) && $stable(cnt_q)));

  p_snooze_quiet_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    snooze |-> !rd_drive);
endmodule

bind bsram_front bsram_front_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .snooze   (snooze),
  .ld_n     (ld_n),
  .adv_n    (adv_n),
  .en_a_n   (en_a_n),
  .en_b_n   (en_b_n),
  .en_c     (en_c),
  .wr_all_n (wr_all_n),
  .oe_n     (oe_n),
  .rd_drive (rd_drive),
  .rd_data  (rd_data),
  .sel_q    (sel_q),
  .cnt_q    (cnt_q),
  .lane_we  (lane_we),
  .op       (op)
);

// File: tb/bsram_front_tb_top.sv
`timescale 1ns/1ps
module bsram_front_tb_top;
  import bsram_pkg::*;

  localparam int unsigned LANES  = 4;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DW     = LANES * LANE_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              snooze;
  logic [ADDR_W-1:0] addr;
  logic              ld_n, adv_n, en_a_n, en_b_n, en_c;
  logic              wr_all_n, wr_byte_n;
  logic [LANES-1:0]  lane_n;
  logic [DW-1:0]     wr_data;
  logic              oe_n;
  logic              rd_drive;
  logic [DW-1:0]     rd_data;

  always #2 clk = ~clk;

  bsram_front #(.LANES(LANES), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .snooze(snooze), .addr(addr), .ld_n(ld_n),
    .adv_n(adv_n), .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .wr_data(wr_data), .oe_n(oe_n), .rd_drive(rd_drive), .rd_data(rd_data)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // Reference model state
  logic [DW-1:0] mmem [DEPTH];
  bit            mknown [DEPTH];
  bit            m_sel;
  int            m_hi, m_cnt, m_cyc;
  typedef struct { int due; logic [DW-1:0] d; bit k; } rd_t;
  rd_t           rq[$];
  bit            e_vld, e_k;
  logic [DW-1:0] e_d;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  task automatic push_read(int a);
    rd_t e;
    e.due = m_cyc + 2;
    e.d   = mmem[a];
    e.k   = mknown[a];
    rq.push_back(e);
  endtask

  task automatic model_step();
    int a;
    m_cyc++;
    if (rq.size() > 0 && rq[0].due == m_cyc) begin
      e_vld = 1'b1;
      e_d   = rq[0].d;
      e_k   = rq[0].k;
      void'(rq.pop_front());
    end else begin
      e_vld = 1'b0;
    end
    if (!ld_n && !en_a_n) begin
      m_sel = !en_b_n && en_c;
      m_hi  = int'(addr) / 4;
      m_cnt = int'(addr) % 4;
      if (m_sel) push_read(int'(addr));
    end else if (m_sel) begin
      if (!adv_n) m_cnt = (m_cnt + 1) % 4;
      a = m_hi * 4 + m_cnt;
      if (!wr_all_n) begin
        mmem[a]   = wr_data;
        mknown[a] = 1'b1;
      end else if (!wr_byte_n) begin
        for (int l = 0; l < LANES; l++)
          if (!lane_n[l]) mmem[a][l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
      end else begin
        push_read(a);
      end
    end
  endtask

  task automatic compare();
    bit exp_drive;
    exp_drive = e_vld && !oe_n && !snooze;
    check(cur_req, DW'(rd_drive), DW'(exp_drive), "rd_drive");
    if (!exp_drive || e_k) check(cur_req, rd_data, exp_drive ? e_d : '0, "rd_data");
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n && !snooze) model_step();
    #1 compare();
  endtask

  task automatic idle();
    ld_n = 1'b1; adv_n = 1'b1; en_a_n = 1'b1; en_b_n = 1'b1; en_c = 1'b0;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_n = '1; wr_data = '0;
    addr = ADDR_W'($urandom());
  endtask

  task automatic load(int a, bit b_n = 1'b0, bit c = 1'b1);
    idle();
    ld_n = 1'b0; en_a_n = 1'b0; en_b_n = b_n; en_c = c; addr = ADDR_W'(a);
    tick();
  endtask

  task automatic beat(bit adv, bit gw, bit bw, logic [LANES-1:0] lanes, logic [DW-1:0] d);
    idle();
    adv_n = !adv; wr_all_n = !gw; wr_byte_n = !bw; lane_n = lanes; wr_data = d;
    // chip enables toggled off the load cycle must not matter (R2)
    en_b_n = $urandom(); en_c = $urandom();
    tick();
  endtask

  task automatic drain(int n);
    idle();
    repeat (n) tick();
  endtask

  task automatic rd_burst(int a);
    load(a);
    repeat (3) beat(1'b1, 1'b0, 1'b0, '1, '0);
    drain(3);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b1; snooze = 1'b0; oe_n = 1'b0;
    m_sel = 1'b0; m_hi = 0; m_cnt = 0; m_cyc = 0; e_vld = 1'b0; e_k = 1'b0; e_d = '0;
    for (int i = 0; i < DEPTH; i++) begin mmem[i] = '0; mknown[i] = 1'b0; end
    idle();
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", DW'(rd_drive), '0, "rd_drive in reset");
    check("R1", rd_data, '0, "rd_data in reset");
    rst_n = 1'b1;
    drain(4);

    // R6 fill: global write overrides byte strobe and lane mask; first beat holds (R5)
    cur_req = "R6";
    for (int b = 0; b < DEPTH; b += 4) begin
      load(b);
      beat(1'b0, 1'b1, b[2], 4'b0101, rnd());
      repeat (3) beat(1'b1, 1'b1, 1'b1, 4'b1110, rnd());
    end
    drain(3);

    // R8 read burst with wrap 9,10,11,8 (R4)
    cur_req = "R8";
    rd_burst(9);

    // R4 wait states
    cur_req = "R4";
    load(22);
    beat(1'b0, 1'b0, 1'b0, '1, '0);
    beat(1'b0, 1'b0, 1'b0, '1, '0);
    beat(1'b1, 1'b0, 1'b0, '1, '0);
    beat(1'b1, 1'b0, 1'b0, '1, '0);
    beat(1'b0, 1'b0, 1'b0, '1, '0);
    drain(3);

    // R7 lane writes with parity bits
    cur_req = "R7";
    load(13);
    beat(1'b0, 1'b0, 1'b1, 4'b1010, rnd());
    beat(1'b1, 1'b0, 1'b1, 4'b0111, rnd());
    beat(1'b1, 1'b0, 1'b1, 4'b1111, rnd());
    beat(1'b1, 1'b0, 1'b1, 4'b0000, rnd());
    drain(2);
    rd_burst(12);

    // R5 write strobes on the load cycle are ignored; next beat writes loaded address
    cur_req = "R5";
    idle();
    ld_n = 1'b0; en_a_n = 1'b0; en_b_n = 1'b0; en_c = 1'b1; addr = 5'd4;
    wr_all_n = 1'b0; wr_data = rnd();
    tick();
    beat(1'b0, 1'b1, 1'b0, '1, rnd());
    beat(1'b1, 1'b1, 1'b0, '1, rnd());
    drain(2);
    rd_burst(4);

    // R2 / R9 deselected loads
    cur_req = "R9";
    load(8, 1'b1, 1'b1);
    beat(1'b0, 1'b1, 1'b0, '1, rnd());
    beat(1'b1, 1'b1, 1'b0, '1, rnd());
    beat(1'b1, 1'b0, 1'b0, '1, '0);
    cur_req = "R2";
    load(24, 1'b0, 1'b0);
    beat(1'b0, 1'b1, 1'b0, '1, rnd());
    beat(1'b1, 1'b0, 1'b1, 4'b0000, rnd());
    drain(3);
    rd_burst(8);
    rd_burst(24);

    // R3 strobe without en_a_n is ignored
    cur_req = "R3";
    load(16);
    idle(); ld_n = 1'b0; en_b_n = 1'b0; en_c = 1'b1; addr = 5'd28; adv_n = 1'b0;
    tick();
    beat(1'b1, 1'b0, 1'b0, '1, '0);
    drain(3);
    load(0, 1'b1, 1'b1);
    idle(); ld_n = 1'b0; en_b_n = 1'b0; en_c = 1'b1; addr = 5'd0;
    tick();
    beat(1'b0, 1'b1, 1'b0, '1, rnd());
    drain(3);
    rd_burst(0);

    // R10 output enable gating, asynchronous
    cur_req = "R10";
    load(1);
    beat(1'b1, 1'b0, 1'b0, '1, '0);
    oe_n = 1'b1;
    beat(1'b1, 1'b0, 1'b0, '1, '0);
    #1 oe_n = 1'b0;
    #0.5 compare();
    oe_n = 1'b1;
    #0.5 compare();
    beat(1'b1, 1'b0, 1'b0, '1, '0);
    oe_n = 1'b0;
    drain(3);

    // R11 snooze freezes everything
    cur_req = "R11";
    load(2);
    beat(1'b1, 1'b0, 1'b0, '1, '0);
    snooze = 1'b1;
    #0.5 compare();
    ld_n = 1'b0; en_a_n = 1'b0; en_b_n = 1'b0; en_c = 1'b1; addr = 5'd30;
    wr_all_n = 1'b0; wr_data = rnd(); adv_n = 1'b0;
    repeat (3) tick();
    snooze = 1'b0;
    beat(1'b1, 1'b0, 1'b0, '1, '0);
    beat(1'b1, 1'b0, 1'b0, '1, '0);
    drain(3);
    rd_burst(28);

    // R8 final readback of every word
    cur_req = "R8";
    for (int b = 0; b < DEPTH; b += 4) rd_burst(b);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule